// File: doc/BRIEF.md
# Serial Audio Data-Request Status

This block keeps the data-request status of a multichannel serial audio port. It sits between the processor-visible holding registers and the serial shift register. It has one holding register for each direction. A direction select chooses which one drives the status. The processor fills the transmit holding register and drains the receive holding register. The shift-register side unloads received words into the receive holding register and loads transmit words out of the transmit holding register.

The block produces four kinds of output:
- a polled request flag;
- an interrupt line that is the flag gated by an enable;
- a 2-bit channel index;
- two sticky error flags, one for transmit underflow and one for receive overflow.

The channel index moves with shift-register hand-offs, never with processor accesses. In transmit it names the channel whose word should be written next. In receive it names the channel of the word now held.

Each holding register is a two-state machine:
- **Transmit:** `TXH_EMPTY` and `TXH_FULL`. The transition `tx_fill` (a processor write) goes to full. The transition `tx_drain` (a load with no write in the same cycle) goes from full to empty. The transition `tx_clear` (a direction change) forces empty. A load in `TXH_EMPTY` is the `tx_starve` self-loop: it resends the previous word.
- **Receive:** `RXH_IDLE` and `RXH_UNREAD`. The transition `rx_capture` (an unload) goes to unread. The transition `rx_consume` (a read with no unload in the same cycle) goes to idle. The transition `rx_clear` forces idle. An unload in `RXH_UNREAD` without a read is the `rx_clobber` self-loop.

Top module: `audreq_status`

## Requirements
- R1: After reset the block is in receive mode with `dreq`=0, `irq`=0, `chan`=0, both sticky flags 0, and `cpu_rdata` and `ser_tx_word` both 0.
- R2: `irq` equals `dreq` AND `irq_en` at all times. Changing `irq_en` never changes `dreq`. `dreq` has no write path.
- R3: In receive mode (`mode_tx`=0), an unload sets `dreq` from the next cycle. A processor read with no unload in the same cycle clears `dreq` from the next cycle. A read and an unload in the same cycle leave `dreq` at 1.
- R4: In transmit mode (`mode_tx`=1), `dreq` is 1 while the transmit holding register is empty and 0 while it is full. A write makes it full from the next cycle. A load of a full register puts its word on `ser_tx_word` and makes it empty from the next cycle, unless a write occurs in the same cycle.
- R5: A load while the transmit holding register is empty leaves `ser_tx_word` unchanged. It also sets `tx_underflow` from the next cycle, and the flag stays set until the next direction change.
- R6: An unload while a receive word is unread and not read in that cycle overwrites `cpu_rdata` with the new word. It also sets `rx_overflow` from the next cycle, and the flag stays set until the next direction change.
- R7: In transmit mode, `chan` equals the number of loads since entering the mode, modulo `NUM_CH`. Writes have no effect on it.
- R8: In receive mode, `chan` is the channel of the word in the receive holding register. That channel is the number of unloads before it since entering the mode, modulo `NUM_CH`. `chan` is 0 before the first unload.
- R9: A direction change is any cycle where `mode_tx` differs from the mode registered in the previous cycle. In such a cycle all strobes are ignored. From the next cycle both holding registers are empty, the channel counter and `chan` are 0, and both sticky flags are 0.
- R10: Strobes for the inactive direction have no effect. These are write and load in receive mode, and read and unload in transmit mode.
- R11: `cpu_rdata` shows the last word unloaded, from the cycle after the unload. `ser_tx_word` shows the last word taken by a load from a full register, from the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tx | input | 1 | Direction select: 1 transmit, 0 receive |
| irq_en | input | 1 | Interrupt enable |
| cpu_wr_tx | input | 1 | Processor write strobe for the transmit holding register |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rd_rx | input | 1 | Processor read strobe for the receive holding register |
| cpu_rdata | output | DATA_W | Receive holding register contents |
| ser_load | input | 1 | Shift register takes a transmit word |
| ser_tx_word | output | DATA_W | Word handed to the shift register |
| ser_unload | input | 1 | Shift register delivers a receive word |
| ser_rx_word | input | DATA_W | Word delivered by the shift register |
| dreq | output | 1 | Data-request flag |
| irq | output | 1 | Masked interrupt |
| chan | output | 2 | Current channel index |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_overflow | output | 1 | Sticky receive overflow |

## Verification
Every registered result is due exactly one clock edge after the strobe that causes it. This covers `dreq`, `chan`, both sticky flags, both data words, and the clear that follows a direction change. `irq` follows `irq_en` combinationally within the same cycle.

The bench drives each cycle's strobes at a falling edge. It advances its arithmetic model for the rising edge in between, and compares every output at the next falling edge. A one-cycle early or late response therefore shows up as a mismatch. The sweep mixes both directions, simultaneous strobes and mode flips drawn from a pseudo-random stream, with a channel count of 3 so the counter wrap is exercised.

// File: rtl/audreq_pkg.sv
package audreq_pkg;

    localparam int CH_W = 2;

    typedef enum logic {
        TXH_EMPTY = 1'b0,
        TXH_FULL  = 1'b1
    } txh_state_e;

    typedef enum logic {
        RXH_IDLE   = 1'b0,
        RXH_UNREAD = 1'b1
    } rxh_state_e;

endpackage

// File: rtl/audreq_chan_ctr.sv
module audreq_chan_ctr
    import audreq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    output logic [CH_W-1:0] count
);

    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    generate
        if (NUM_CH <= 1) begin : g_single
            assign count = '0;
        end else begin : g_multi
            logic [CH_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt_q <= '0;
                end else if (adv) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign count = cnt_q;
        end
    endgenerate

endmodule

// File: rtl/audreq_tx_hold.sv
module audreq_tx_hold
    import audreq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic              req,
    output logic [DATA_W-1:0] shift_word,
    output logic              underflow
);

    txh_state_e        state_q, state_nx;
    logic              wr_go, load_go;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              unf_q;

    assign wr_go   = en && wr;
    assign load_go = en && load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXH_EMPTY;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: tx_fill, tx_drain, tx_clear, tx_starve
    always_comb begin
        state_nx = state_q;
        if (clr) begin
            state_nx = TXH_EMPTY;
        end else begin
            unique case (state_q)
                TXH_EMPTY: if (wr_go)              state_nx = TXH_FULL;
                TXH_FULL:  if (load_go && !wr_go)  state_nx = TXH_EMPTY;
                default:                           state_nx = TXH_EMPTY;
            endcase
        end
    end

    // datapath and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            unf_q   <= 1'b0;
        end else begin
            if (wr_go) begin
                hold_q <= wdata;
            end
            if (load_go && state_q == TXH_FULL) begin
                shift_q <= hold_q;
            end
            if (clr) begin
                unf_q <= 1'b0;
            end else if (load_go && state_q == TXH_EMPTY) begin
                unf_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req        = (state_q == TXH_EMPTY);
        shift_word = shift_q;
        underflow  = unf_q;
    end

endmodule

// File: rtl/audreq_rx_hold.sv
module audreq_rx_hold
    import audreq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              unload,
    input  logic [DATA_W-1:0] word,
    input  logic [CH_W-1:0]   ch_in,
    input  logic              rd,
    output logic              req,
    output logic [DATA_W-1:0] rdata,
    output logic [CH_W-1:0]   tag,
    output logic              overflow
);

    rxh_state_e        state_q, state_nx;
    logic              unload_go, rd_go;
    logic [DATA_W-1:0] hold_q;
    logic [CH_W-1:0]   tag_q;
    logic              ovf_q;

    assign unload_go = en && unload;
    assign rd_go     = en && rd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXH_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: rx_capture, rx_consume, rx_clear, rx_clobber
    always_comb begin
        state_nx = state_q;
        if (clr) begin
            state_nx = RXH_IDLE;
        end else begin
            unique case (state_q)
                RXH_IDLE:   if (unload_go)              state_nx = RXH_UNREAD;
                RXH_UNREAD: if (rd_go && !unload_go)    state_nx = RXH_IDLE;
                default:                                state_nx = RXH_IDLE;
            endcase
        end
    end

    // datapath, channel tag and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            tag_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (unload_go) begin
                hold_q <= word;
            end
            if (clr) begin
                tag_q <= '0;
            end else if (unload_go) begin
                tag_q <= ch_in;
            end
            if (clr) begin
                ovf_q <= 1'b0;
            end else if (unload_go && state_q == RXH_UNREAD && !rd_go) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req      = (state_q == RXH_UNREAD);
        rdata    = hold_q;
        tag      = tag_q;
        overflow = ovf_q;
    end

endmodule

// File: rtl/audreq_status.sv
module audreq_status
    import audreq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_tx,
    input  logic              irq_en,
    input  logic              cpu_wr_tx,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd_rx,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              ser_load,
    output logic [DATA_W-1:0] ser_tx_word,
    input  logic              ser_unload,
    input  logic [DATA_W-1:0] ser_rx_word,
    output logic              dreq,
    output logic              irq,
    output logic [1:0]        chan,
    output logic              tx_underflow,
    output logic              rx_overflow
);

    logic            mode_q;
    logic            mode_sw;
    logic            tx_en, rx_en;
    logic            adv;
    logic [CH_W-1:0] ctr;
    logic [CH_W-1:0] rx_tag;
    logic            tx_req, rx_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_tx;
        end
    end

    assign mode_sw = (mode_tx != mode_q);
    assign tx_en   = mode_q && !mode_sw;
    assign rx_en   = !mode_q && !mode_sw;
    assign adv     = (tx_en && ser_load) || (rx_en && ser_unload);

    audreq_chan_ctr #(.NUM_CH(NUM_CH)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_sw),
        .adv   (adv),
        .count (ctr)
    );

    audreq_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (mode_sw),
        .en         (tx_en),
        .wr         (cpu_wr_tx),
        .wdata      (cpu_wdata),
        .load       (ser_load),
        .req        (tx_req),
        .shift_word (ser_tx_word),
        .underflow  (tx_underflow)
    );

    audreq_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mode_sw),
        .en       (rx_en),
        .unload   (ser_unload),
        .word     (ser_rx_word),
        .ch_in    (ctr),
        .rd       (cpu_rd_rx),
        .req      (rx_req),
        .rdata    (cpu_rdata),
        .tag      (rx_tag),
        .overflow (rx_overflow)
    );

    always_comb begin
        dreq = mode_q ? tx_req : rx_req;
        irq  = dreq && irq_en;
        chan = mode_q ? ctr : rx_tag;
    end

endmodule

// File: rtl/audreq_status_chk.sv
module audreq_status_chk #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_q,
    input logic              mode_sw,
    input logic              irq_en,
    input logic              cpu_wr_tx,
    input logic              cpu_rd_rx,
    input logic              ser_load,
    input logic              ser_unload,
    input logic              dreq,
    input logic              irq,
    input logic [1:0]        chan,
    input logic [DATA_W-1:0] ser_tx_word,
    input logic              tx_underflow,
    input logic              rx_overflow
);

    localparam logic [2:0] LIM = 3'(NUM_CH);

    p_irq_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> dreq);

    p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_rx_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !mode_sw && ser_unload) |=> dreq);

    p_rx_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !mode_sw && cpu_rd_rx && !ser_unload) |=> !dreq);

    p_tx_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !mode_sw && cpu_wr_tx) |=> !dreq);

    p_tx_starve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !mode_sw && ser_load && dreq) |=> (tx_underflow && $stable(ser_tx_word)));

    p_unf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && !mode_sw) |=> tx_underflow);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !mode_sw) |=> rx_overflow);

    p_chan_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, chan} < LIM));

    p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sw |=> (chan == 2'd0 && !tx_underflow && !rx_overflow));

endmodule

bind audreq_status audreq_status_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .mode_sw      (mode_sw),
    .irq_en       (irq_en),
    .cpu_wr_tx    (cpu_wr_tx),
    .cpu_rd_rx    (cpu_rd_rx),
    .ser_load     (ser_load),
    .ser_unload   (ser_unload),
    .dreq         (dreq),
    .irq          (irq),
    .chan         (chan),
    .ser_tx_word  (ser_tx_word),
    .tx_underflow (tx_underflow),
    .rx_overflow  (rx_overflow)
);

// File: tb/audreq_status_test.sv
`timescale 1ns/1ps
module audreq_status_test;

    localparam int DW  = 8;
    localparam int NCH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_tx = 1'b0, irq_en = 1'b0;
    logic          cpu_wr_tx = 1'b0, cpu_rd_rx = 1'b0;
    logic          ser_load = 1'b0, ser_unload = 1'b0;
    logic [DW-1:0] cpu_wdata = '0, ser_rx_word = '0;
    logic [DW-1:0] cpu_rdata, ser_tx_word;
    logic          dreq, irq, tx_underflow, rx_overflow;
    logic [1:0]    chan;

    always #2.5 clk = ~clk;

    audreq_status #(.DATA_W(DW), .NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .irq_en(irq_en),
        .cpu_wr_tx(cpu_wr_tx), .cpu_wdata(cpu_wdata), .cpu_rd_rx(cpu_rd_rx),
        .cpu_rdata(cpu_rdata), .ser_load(ser_load), .ser_tx_word(ser_tx_word),
        .ser_unload(ser_unload), .ser_rx_word(ser_rx_word), .dreq(dreq),
        .irq(irq), .chan(chan), .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model of the requirements
    bit      m_mode, m_txfull, m_unread, m_unf, m_ovf;
    int      m_ctr, m_tag, m_txhold, m_sent, m_rxhold;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int e_dreq;
        e_dreq = m_mode ? int'(!m_txfull) : int'(m_unread);
        chk(m_mode ? "R4" : "R3", "dreq", int'(dreq), e_dreq);
        chk("R2", "irq", int'(irq), e_dreq & int'(irq_en));
        chk(m_mode ? "R7" : "R8", "chan", int'(chan), m_mode ? m_ctr : m_tag);
        chk("R5", "tx_underflow", int'(tx_underflow), int'(m_unf));
        chk("R6", "rx_overflow", int'(rx_overflow), int'(m_ovf));
        chk("R11", "cpu_rdata", int'(cpu_rdata), m_rxhold);
        chk("R11", "ser_tx_word", int'(ser_tx_word), m_sent);
    endtask

    // one cycle: drive at a falling edge, model the rising edge, compare at the next falling edge
    task automatic cyc(bit md, bit ie, bit wr, int wd, bit rd, bit ld, bit ul, int rw);
        mode_tx = md; irq_en = ie;
        cpu_wr_tx = wr; cpu_wdata = DW'(wd); cpu_rd_rx = rd;
        ser_load = ld; ser_unload = ul; ser_rx_word = DW'(rw);
        if (md != m_mode) begin
            m_mode = md; m_txfull = 0; m_unread = 0; m_ctr = 0; m_tag = 0;
            m_unf = 0; m_ovf = 0;
        end else if (m_mode) begin
            if (ld) begin
                if (m_txfull) begin m_sent = m_txhold; m_txfull = 0; end
                else m_unf = 1;
                m_ctr = (m_ctr + 1) % NCH;
            end
            if (wr) begin m_txhold = wd & 8'hFF; m_txfull = 1; end
        end else begin
            if (ul) begin
                if (m_unread && !rd) m_ovf = 1;
                m_rxhold = rw & 8'hFF; m_tag = m_ctr; m_ctr = (m_ctr + 1) % NCH;
                m_unread = 1;
            end else if (rd) begin
                m_unread = 0;
            end
        end
        @(negedge clk);
        cpu_wr_tx = 0; cpu_rd_rx = 0; ser_load = 0; ser_unload = 0;
        compare_all();
    endtask

    initial begin
        int unsigned x;
        bit md;
        m_mode = 0; m_txfull = 0; m_unread = 0; m_unf = 0; m_ovf = 0;
        m_ctr = 0; m_tag = 0; m_txhold = 0; m_sent = 0; m_rxhold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "dreq", int'(dreq), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "chan", int'(chan), 0);
        chk("R1", "flags", int'(tx_underflow) + int'(rx_overflow), 0);
        chk("R1", "words", int'(cpu_rdata) + int'(ser_tx_word), 0);

        // receive directed
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h11);
        chk("R3", "dreq after unload", int'(dreq), 1);
        chk("R8", "chan of first word", int'(chan), 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h22);
        chk("R6", "overflow", int'(rx_overflow), 1);
        chk("R6", "overwritten word", int'(cpu_rdata), 8'h22);
        chk("R8", "chan of second word", int'(chan), 1);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R3", "dreq after read", int'(dreq), 0);
        cyc(0, 1, 0, 0, 0, 0, 1, 8'h33);
        chk("R2", "irq enabled", int'(irq), 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", "dreq kept when masked", int'(dreq), 1);
        chk("R2", "irq masked", int'(irq), 0);
        cyc(0, 0, 1, 8'h77, 0, 1, 0, 0);
        chk("R10", "tx strobes in rx: ser_tx_word", int'(ser_tx_word), 0);
        chk("R10", "tx strobes in rx: chan", int'(chan), 2);

        // direction change with a strobe that must be ignored
        cyc(1, 0, 0, 0, 0, 1, 0, 0);
        chk("R9", "tx empty after switch", int'(dreq), 1);
        chk("R9", "chan cleared", int'(chan), 0);
        chk("R9", "overflow cleared", int'(rx_overflow), 0);
        chk("R9", "no underflow from ignored load", int'(tx_underflow), 0);

        // transmit directed
        cyc(1, 0, 1, 8'h5A, 0, 0, 0, 0);
        chk("R4", "dreq after write", int'(dreq), 0);
        cyc(1, 0, 0, 0, 0, 1, 0, 0);
        chk("R4", "word sent", int'(ser_tx_word), 8'h5A);
        chk("R4", "dreq after load", int'(dreq), 1);
        cyc(1, 0, 0, 0, 1, 1, 1, 8'h99);
        chk("R5", "underflow", int'(tx_underflow), 1);
        chk("R5", "word resent", int'(ser_tx_word), 8'h5A);
        chk("R7", "chan advances without write", int'(chan), 2);
        chk("R10", "rx strobes in tx: cpu_rdata", int'(cpu_rdata), 8'h33);
        cyc(1, 0, 0, 0, 0, 1, 0, 0);
        chk("R7", "chan wraps", int'(chan), 0);

        // pseudo-random sweep over both directions
        x = 32'h1234_5679;
        md = 1;
        for (int i = 0; i < 4000; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            if (x[31:27] == 5'd0) md = !md;
            cyc(md, x[0], x[1], int'(x[15:8]), x[2], x[3], x[4], int'(x[23:16]));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule